// File: doc/BRIEF.md
# Byte-Wide SPI Controller with Register Interface

This block is a byte-wide serial peripheral controller driven by a CPU through three 8-bit registers at word addresses 0 to 2. One register is the shared shift/data byte. One selects the operating mode and holds the enable and transfer-done bits. The third selects the bit order and holds the write-collision flag. A 3-bit mode field chooses one of three things. The first is master operation, with the serial clock taken from one of three system-clock dividers, from a slow-clock tick or from a timer-match tick. The second is slave operation, with the clock taken from an external master. The third is an off setting.

The controller uses SPI mode 0. The serial clock idles low, the outgoing bit changes on the falling edge and the incoming bit is sampled on the rising edge. In slave mode the external clock, data and select are brought into the system clock domain through two-flop synchronizers before edge detection.

The transfer state machine has four states. IDLE waits for work. M_LOW is the master clock-low half period. M_HIGH is the master clock-high half period. S_SEL is the slave with select asserted. The transitions are as follows:
- IDLE goes to M_LOW on a data write while master is enabled.
- IDLE goes to S_SEL when the synchronized select falls while slave is enabled.
- M_LOW goes to M_HIGH on a half-period tick. This is the rising edge, where the input bit is sampled.
- M_HIGH goes to M_LOW on a tick if bits remain. This is the falling edge, where the register shifts.
- M_HIGH goes to IDLE on the tick after the eighth bit.
- S_SEL goes to IDLE when select rises.
- Any master state goes to IDLE when master operation is disabled.

Top module: `spi_port_ctrl`

## Requirements
- R1: After reset the control register (address 1) reads 0xE0: mode field [7:5]=111 and the debounce bits [3:2], enable bit [1] and done bit [0] all 0. The auxiliary register (address 2) reads 0x00. Control bit 4 always reads 0, even after a write of 1.
- R2: In master mode 000 with enable set, a write to the data register (address 0) while idle starts an 8-bit transfer. Counting t from the capturing clock edge, SCK is high when (t/2) is odd for t<32. SDO shows bit t/4 of the written byte, and SDI is sampled on each rising SCK edge.
- R3: Modes 001 and 010 give SCK half periods of 8 and 32 system clocks with the same timing rule as R2.
- R4: Mode 011 toggles SCK once for each `sub_tick` pulse. Mode 100 toggles SCK once for each `tmr_tick` pulse. Sixteen pulses complete a byte.
- R5: Auxiliary bit 1 selects the bit order. 0 sends and receives MSB first; 1 sends and receives LSB first.
- R6: On the final falling edge of the eighth bit, control bit 0 (done) sets and the data register holds the received byte. Writing 0 to bit 0 clears done.
- R7: A data-register write during a transfer is ignored (the transfer and its received byte are unaffected) and sets auxiliary bit 0 (write collision). Writing 0 to that bit clears it.
- R8: Mode 101 is slave. The synchronized external SCK shifts the byte in mode 0, SDO presents the outgoing bit, `spi_sck_o` stays low, and done sets after eight bits.
- R9: In slave mode, deasserting select in the middle of a byte aborts the byte without setting done, and the next byte starts again from bit 0.
- R10: With enable 0, or with mode 110 or 111, `spi_sck_o` and `spi_sdo` stay low and a data write starts no transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 2 | Register address: 0 data, 1 control, 2 auxiliary |
| bus_wr | input | 1 | Register write strobe |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data for `bus_addr` |
| sub_tick | input | 1 | Slow-clock tick, one pulse per SCK half period in mode 011 |
| tmr_tick | input | 1 | Timer-match tick, one pulse per SCK half period in mode 100 |
| spi_sck_o | output | 1 | Serial clock driven in master mode |
| spi_sck_i | input | 1 | Serial clock from an external master in slave mode |
| spi_sdo | output | 1 | Serial data out |
| spi_sdi | input | 1 | Serial data in |
| spi_ss_n | input | 1 | Active-low slave select |

## Verification
The bench builds the block with its default dividers of 4, 16 and 64. With these values all three divider modes can be compared against a per-cycle model of SCK and SDO, and a full byte at the slowest rate still takes only 512 clocks. The tick-driven modes are stepped one pulse at a time. Slave transfers use an 8-clock half period, which leaves the synchronizer delay well inside every bit.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;

    typedef enum logic [2:0] {
        MD_DIV_A  = 3'b000,
        MD_DIV_B  = 3'b001,
        MD_DIV_C  = 3'b010,
        MD_SUB    = 3'b011,
        MD_TMR    = 3'b100,
        MD_SLAVE  = 3'b101,
        MD_RSVD   = 3'b110,
        MD_OFF    = 3'b111
    } spi_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_M_LOW,
        ST_M_HIGH,
        ST_S_SEL
    } xfer_state_e;

    localparam logic [1:0] ADDR_DATA = 2'd0;
    localparam logic [1:0] ADDR_CTRL = 2'd1;
    localparam logic [1:0] ADDR_AUX  = 2'd2;

endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
    parameter int              W       = 1,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta <= RST_VAL;
            q    <= RST_VAL;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/spi_rate_gen.sv
module spi_rate_gen
    import spi_port_pkg::*;
#(
    parameter int DIV_A = 4,
    parameter int DIV_B = 16,
    parameter int DIV_C = 64
) (
    input  logic      clk,
    input  logic      rst_n,
    input  spi_mode_e mode,
    input  logic      run,
    input  logic      sub_tick,
    input  logic      tmr_tick,
    output logic      half_tick
);
    localparam int HALF_MAX = DIV_C / 2;
    localparam int CW       = $clog2(HALF_MAX) + 1;

    logic [CW-1:0] cnt;
    logic [CW-1:0] lim;

    always_comb begin
        case (mode)
            MD_DIV_A: lim = CW'(DIV_A / 2 - 1);
            MD_DIV_B: lim = CW'(DIV_B / 2 - 1);
            default:  lim = CW'(DIV_C / 2 - 1);
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt <= '0;
        else if (!run)       cnt <= '0;
        else if (cnt == lim) cnt <= '0;
        else                 cnt <= cnt + 1'b1;
    end

    always_comb begin
        case (mode)
            MD_DIV_A, MD_DIV_B, MD_DIV_C: half_tick = run && (cnt == lim);
            MD_SUB:                        half_tick = run && sub_tick;
            MD_TMR:                        half_tick = run && tmr_tick;
            default:                       half_tick = 1'b0;
        endcase
    end
endmodule

// File: rtl/spi_xfer_fsm.sv
module spi_xfer_fsm
    import spi_port_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       master_en,
    input  logic       slave_en,
    input  logic       half_tick,
    input  logic       lsb_first,
    input  logic       load,
    input  logic [7:0] load_byte,
    input  logic       m_sdi,
    input  logic       s_sck,
    input  logic       s_sdi,
    input  logic       s_ss_n,
    output logic [7:0] shreg,
    output logic       busy,
    output logic       done_pulse,
    output logic       sck_o,
    output logic       sdo_o
);
    xfer_state_e state, nxt;
    logic [2:0]  bit_cnt;
    logic        samp;
    logic        s_sck_d;
    logic        s_rise, s_fall;
    logic        shift_now, samp_now;
    logic        slave_live;

    assign s_rise     = s_sck & ~s_sck_d;
    assign s_fall     = ~s_sck & s_sck_d;
    assign slave_live = (state == ST_S_SEL) && slave_en && !s_ss_n;
    assign shift_now  = ((state == ST_M_HIGH) && master_en && half_tick) || (slave_live && s_fall);
    assign samp_now   = ((state == ST_M_LOW)  && master_en && half_tick) || (slave_live && s_rise);
    assign done_pulse = shift_now && (bit_cnt == 3'd7);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (master_en && load)        nxt = ST_M_LOW;
                else if (slave_en && !s_ss_n) nxt = ST_S_SEL;
            end
            ST_M_LOW: begin
                if (!master_en)     nxt = ST_IDLE;
                else if (half_tick) nxt = ST_M_HIGH;
            end
            ST_M_HIGH: begin
                if (!master_en)     nxt = ST_IDLE;
                else if (half_tick) nxt = (bit_cnt == 3'd7) ? ST_IDLE : ST_M_LOW;
            end
            ST_S_SEL: begin
                if (!slave_en || s_ss_n) nxt = ST_IDLE;
            end
        endcase
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg   <= '0;
            bit_cnt <= '0;
            samp    <= 1'b0;
            s_sck_d <= 1'b0;
        end else begin
            s_sck_d <= s_sck;
            if (samp_now)
                samp <= (state == ST_S_SEL) ? s_sdi : m_sdi;
            if (load)
                shreg <= load_byte;
            else if (shift_now)
                shreg <= lsb_first ? {samp, shreg[7:1]} : {shreg[6:0], samp};
            if (state == ST_IDLE || (state == ST_S_SEL && s_ss_n))
                bit_cnt <= '0;
            else if (shift_now)
                bit_cnt <= bit_cnt + 1'b1;
        end
    end

    // outputs
    always_comb begin
        busy  = (state != ST_IDLE);
        sck_o = master_en && (state == ST_M_HIGH);
        sdo_o = (master_en || slave_en) && (lsb_first ? shreg[0] : shreg[7]);
    end
endmodule

// File: rtl/spi_port_ctrl.sv
module spi_port_ctrl
    import spi_port_pkg::*;
#(
    parameter int DIV_A = 4,
    parameter int DIV_B = 16,
    parameter int DIV_C = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] bus_addr,
    input  logic       bus_wr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       sub_tick,
    input  logic       tmr_tick,
    output logic       spi_sck_o,
    input  logic       spi_sck_i,
    output logic       spi_sdo,
    input  logic       spi_sdi,
    input  logic       spi_ss_n
);
    spi_mode_e  mode_q;
    logic [1:0] dbnc_q;
    logic       en_q, done_q, lsb_q, wcol_q;
    logic       master_en, slave_en, busy, done_pulse, half_tick;
    logic       wr_data, wr_ctrl, wr_aux, load;
    logic [7:0] shreg;
    logic [2:0] sync_q;

    assign master_en = en_q && (mode_q inside {MD_DIV_A, MD_DIV_B, MD_DIV_C, MD_SUB, MD_TMR});
    assign slave_en  = en_q && (mode_q == MD_SLAVE);
    assign wr_data   = bus_wr && (bus_addr == ADDR_DATA);
    assign wr_ctrl   = bus_wr && (bus_addr == ADDR_CTRL);
    assign wr_aux    = bus_wr && (bus_addr == ADDR_AUX);
    assign load      = wr_data && !busy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= MD_OFF;
            dbnc_q <= '0;
            en_q   <= 1'b0;
            done_q <= 1'b0;
            lsb_q  <= 1'b0;
            wcol_q <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                mode_q <= spi_mode_e'(bus_wdata[7:5]);
                dbnc_q <= bus_wdata[3:2];
                en_q   <= bus_wdata[1];
                done_q <= done_pulse | (done_q & bus_wdata[0]);
            end else begin
                done_q <= done_q | done_pulse;
            end
            if (wr_aux) begin
                lsb_q  <= bus_wdata[1];
                wcol_q <= (wr_data && busy) | (wcol_q & bus_wdata[0]);
            end else begin
                wcol_q <= wcol_q | (wr_data && busy);
            end
        end
    end

    always_comb begin
        case (bus_addr)
            ADDR_DATA: bus_rdata = shreg;
            ADDR_CTRL: bus_rdata = {mode_q, 1'b0, dbnc_q, en_q, done_q};
            ADDR_AUX:  bus_rdata = {6'b0, lsb_q, wcol_q};
            default:   bus_rdata = 8'h00;
        endcase
    end

    spi_sync #(.W(3), .RST_VAL(3'b001)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({spi_sck_i, spi_sdi, spi_ss_n}),
        .q     (sync_q)
    );

    spi_rate_gen #(.DIV_A(DIV_A), .DIV_B(DIV_B), .DIV_C(DIV_C)) u_rate (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode_q),
        .run       (master_en && busy),
        .sub_tick  (sub_tick),
        .tmr_tick  (tmr_tick),
        .half_tick (half_tick)
    );

    spi_xfer_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .master_en  (master_en),
        .slave_en   (slave_en),
        .half_tick  (half_tick),
        .lsb_first  (lsb_q),
        .load       (load),
        .load_byte  (bus_wdata),
        .m_sdi      (spi_sdi),
        .s_sck      (sync_q[2]),
        .s_sdi      (sync_q[1]),
        .s_ss_n     (sync_q[0]),
        .shreg      (shreg),
        .busy       (busy),
        .done_pulse (done_pulse),
        .sck_o      (spi_sck_o),
        .sdo_o      (spi_sdo)
    );
endmodule

// File: rtl/spi_port_ctrl_chk.sv
module spi_port_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] bus_addr,
    input logic       bus_wr,
    input logic [7:0] bus_rdata,
    input logic       spi_sck_o,
    input logic       spi_sdo,
    input logic [2:0] mode_bits,
    input logic       en_bit,
    input logic       busy,
    input logic       done_bit,
    input logic       wcol_bit
);
    p_bit4_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 2'd1) |-> !bus_rdata[4]);

    p_done_at_idle_clock_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_bit) |-> !spi_sck_o);

    p_collision_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd0 && busy) |=> wcol_bit);

    p_slave_no_clock_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_bits == 3'b101) |-> !spi_sck_o);

    p_quiet_when_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_bit || mode_bits == 3'b110 || mode_bits == 3'b111) |-> (!spi_sck_o && !spi_sdo));
endmodule

bind spi_port_ctrl spi_port_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rdata (bus_rdata),
    .spi_sck_o (spi_sck_o),
    .spi_sdo   (spi_sdo),
    .mode_bits (mode_q),
    .en_bit    (en_q),
    .busy      (busy),
    .done_bit  (done_q),
    .wcol_bit  (wcol_q)
);

// File: tb/tb_spi_port_ctrl.sv
`timescale 1ns/1ps
module tb_spi_port_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       sub_tick = 1'b0, tmr_tick = 1'b0;
    logic       spi_sck_o, spi_sdo;
    logic       spi_sck_i = 1'b0, spi_sdi = 1'b0, spi_ss_n = 1'b1;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    spi_port_ctrl dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sub_tick(sub_tick),
        .tmr_tick(tmr_tick), .spi_sck_o(spi_sck_o), .spi_sck_i(spi_sck_i),
        .spi_sdo(spi_sdo), .spi_sdi(spi_sdi), .spi_ss_n(spi_ss_n)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #0.5 d = bus_rdata;
    endtask

    // behavioural per-cycle model of a master divider transfer
    task automatic master_xfer(input string tag, input logic [7:0] tx, input logic [7:0] rx,
                               input bit lsb, input int half);
        logic [7:0] v;
        wr(2'd0, tx);
        for (int t = 0; t < 16 * half; t++) begin
            int b;
            b = t / (2 * half);
            spi_sdi = lsb ? rx[b] : rx[7 - b];
            #0.5;
            chk({tag, " sck"}, spi_sck_o, (t / half) % 2);
            chk({tag, " sdo"}, spi_sdo, lsb ? tx[b] : tx[7 - b]);
            @(negedge clk);
        end
        #0.5 chk({tag, " sck idle after byte"}, spi_sck_o, 0);
        rd(2'd0, v); chk({tag, " R6 received byte"}, v, rx);
        rd(2'd1, v); chk({tag, " R6 done set"}, v[0], 1);
    endtask

    task automatic tick_xfer(input string tag, input bit use_tmr, input logic [7:0] tx,
                             input logic [7:0] rx);
        logic [7:0] v;
        wr(2'd0, tx);
        for (int k = 1; k <= 16; k++) begin
            spi_sdi = rx[7 - (k - 1) / 2];
            if (use_tmr) tmr_tick = 1'b1; else sub_tick = 1'b1;
            @(negedge clk);
            tmr_tick = 1'b0; sub_tick = 1'b0;
            #0.5 chk({tag, " sck per tick"}, spi_sck_o, k % 2);
            repeat (3) @(negedge clk);
        end
        rd(2'd0, v); chk({tag, " received byte"}, v, rx);
        rd(2'd1, v); chk({tag, " done"}, v[0], 1);
    endtask

    // external master driving the slave, MSB first, half period 8 clocks
    task automatic slave_bits(input string tag, input logic [7:0] tx, input logic [7:0] rx,
                              input int nbits);
        for (int b = 0; b < nbits; b++) begin
            spi_sdi = rx[7 - b];
            #0.5 chk({tag, " slave sdo"}, spi_sdo, tx[7 - b]);
            chk({tag, " R8 no master clock"}, spi_sck_o, 0);
            repeat (8) @(negedge clk);
            spi_sck_i = 1'b1;
            repeat (8) @(negedge clk);
            spi_sck_i = 1'b0;
            repeat (8) @(negedge clk);
        end
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values
        rd(2'd1, v); chk("R1 ctrl reset", v, 8'hE0);
        rd(2'd2, v); chk("R1 aux reset", v, 8'h00);
        wr(2'd1, 8'hF0);
        rd(2'd1, v); chk("R1 bit4 reads zero", v, 8'hE0);

        // R10 disabled settings
        wr(2'd1, 8'hE2);
        wr(2'd0, 8'hFF);
        for (int i = 0; i < 40; i++) begin
            #0.5 chk("R10 mode 111 quiet", {spi_sck_o, spi_sdo}, 0);
            @(negedge clk);
        end
        wr(2'd1, 8'hC2);
        wr(2'd0, 8'hFF);
        for (int i = 0; i < 40; i++) begin
            #0.5 chk("R10 mode 110 quiet", {spi_sck_o, spi_sdo}, 0);
            @(negedge clk);
        end
        wr(2'd1, 8'h00);
        wr(2'd0, 8'hFF);
        for (int i = 0; i < 40; i++) begin
            #0.5 chk("R10 enable off quiet", {spi_sck_o, spi_sdo}, 0);
            @(negedge clk);
        end

        // R2 master fsys/4, MSB first
        wr(2'd1, 8'h02);
        master_xfer("R2 div4", 8'hA5, 8'h3C, 1'b0, 2);
        wr(2'd1, 8'h02);
        rd(2'd1, v); chk("R6 done cleared by zero", v[0], 0);
        master_xfer("R2 div4 b", 8'h81, 8'hE7, 1'b0, 2);

        // R5 LSB first
        wr(2'd2, 8'h02);
        master_xfer("R5 lsb first", 8'h1D, 8'hB2, 1'b1, 2);
        wr(2'd2, 8'h00);

        // R3 other dividers
        wr(2'd1, 8'h22);
        master_xfer("R3 div16", 8'h6E, 8'h91, 1'b0, 8);
        wr(2'd1, 8'h42);
        master_xfer("R3 div64", 8'hC3, 8'h5A, 1'b0, 32);

        // R4 tick-driven clocks
        wr(2'd1, 8'h62);
        tick_xfer("R4 sub tick", 1'b0, 8'h37, 8'hC8);
        wr(2'd1, 8'h82);
        tick_xfer("R4 timer tick", 1'b1, 8'h4B, 8'h2D);

        // R7 write collision
        wr(2'd1, 8'h02);
        spi_sdi = 1'b1;
        wr(2'd0, 8'h12);
        repeat (5) @(negedge clk);
        wr(2'd0, 8'h5A);
        repeat (60) @(negedge clk);
        rd(2'd0, v); chk("R7 colliding write ignored", v, 8'hFF);
        rd(2'd2, v); chk("R7 collision flag set", v[0], 1);
        wr(2'd2, 8'h00);
        rd(2'd2, v); chk("R7 collision flag cleared", v[0], 0);

        // R8 slave transfer
        wr(2'd1, 8'hA2);
        wr(2'd0, 8'h96);
        spi_ss_n = 1'b0;
        repeat (6) @(negedge clk);
        slave_bits("R8", 8'h96, 8'h4E, 8);
        repeat (6) @(negedge clk);
        rd(2'd0, v); chk("R8 slave received byte", v, 8'h4E);
        rd(2'd1, v); chk("R8 slave done", v[0], 1);
        spi_ss_n = 1'b1;
        repeat (6) @(negedge clk);

        // R9 abort mid-byte
        wr(2'd1, 8'hA2);
        wr(2'd0, 8'hF0);
        spi_ss_n = 1'b0;
        repeat (6) @(negedge clk);
        slave_bits("R9 partial", 8'hF0, 8'hAA, 3);
        spi_ss_n = 1'b1;
        repeat (8) @(negedge clk);
        rd(2'd1, v); chk("R9 no done after abort", v[0], 0);
        wr(2'd0, 8'h3C);
        spi_ss_n = 1'b0;
        repeat (6) @(negedge clk);
        slave_bits("R9 restart", 8'h3C, 8'h71, 8);
        repeat (6) @(negedge clk);
        rd(2'd0, v); chk("R9 full byte after abort", v, 8'h71);
        rd(2'd1, v); chk("R9 done after full byte", v[0], 1);
        spi_ss_n = 1'b1;

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule